// File: doc/BRIEF.md
# Coincident-Select Bit RAM

This block is a small array of single-bit storage cells arranged as a matrix of rows and columns. A cell is chosen by coincident selection: one row line and one column line are raised together, and only the cell where they cross takes part in a read or a write. A row line or a column line raised alone selects nothing. The array is addressed by one-hot lines, not by a binary address, so any decoder sits outside the block.

Data goes in through two strobes, one that sets the chosen cell to 1 and one that clears it to 0. In the default build each strobe is qualified by a shared write enable, as a two-input write gate would be. With `SINGLE_GATE` set, the strobe alone writes and the enable has no effect. The stored bit comes out on a complementary pair of active-low sense lines. The "one" line falls for a stored 1 and the "zero" line falls for a stored 0. Both lines stay high when no cell is chosen. Sense is combinational from the cells and the select lines. A write takes effect on the rising clock edge.

Top module: `coincident_ram`

## Requirements
- R1: A synchronous active-high `rst` clears every cell to 0 on the clock edge.
- R2: A cell is chosen only when both its row line and its column line are high. When every row line or every column line is low, both sense outputs are high, and a write strobe changes no cell.
- R3: When no cell is chosen, `sense_one_n` and `sense_zero_n` are both 1.
- R4: When exactly one cell is chosen, `sense_zero_n` is 0 and `sense_one_n` is 1 if the cell holds 0. `sense_one_n` is 0 and `sense_zero_n` is 1 if the cell holds 1.
- R5: With `SINGLE_GATE`=0, a chosen cell becomes 1 at the clock edge when `set_one` and `wr_en` are both high. It becomes 0 when `set_zero` and `wr_en` are both high. When `wr_en` is low, the strobes do nothing.
- R6: A write changes only the cells at the crossing of the raised row and column lines. All other cells keep their contents.
- R7: A written cell keeps its value after the select and write inputs return low.
- R8: With `SINGLE_GATE`=1, `set_one` or `set_zero` alone writes the chosen cell and `wr_en` is ignored.
- R9: When `set_one` and `set_zero` are high in the same cycle, every cell keeps its old value. The bench reports this as an illegal input.
- R10: When more than one cell is chosen (an illegal select), each sense output is the AND of the active-low indications of all chosen cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_sel | input | ROWS | One-hot row select lines, active high |
| col_sel | input | COLS | One-hot column select lines, active high |
| wr_en | input | 1 | Write qualifier (ignored when SINGLE_GATE=1) |
| set_one | input | 1 | Strobe that writes 1 into the chosen cell |
| set_zero | input | 1 | Strobe that writes 0 into the chosen cell |
| sense_one_n | output | 1 | Low when a chosen cell holds 1 |
| sense_zero_n | output | 1 | Low when a chosen cell holds 0 |

## Verification
A wrong cell value stays hidden until that cell is selected again. Only then does it show, in the same cycle, as the wrong sense line going low. For this reason the bench reads back the whole matrix after each group of writes, so that a disturbed neighbour cell is seen as well as the target cell. A fault in select or write gating shows one clock after the offending write, as a readback that differs from the reference model. The two-gate and single-gate builds are compared side by side with the same stimulus, so an error in enable handling shows as the two builds disagreeing where they should, or agreeing where they should not.

// File: rtl/cram_pkg.sv
package cram_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_ZERO  = 2'd1,
    WR_ONE   = 2'd2,
    WR_CLASH = 2'd3
  } wr_act_t;

  // Resolve the two strobes and the qualifier into one write action.
  function automatic wr_act_t resolve_write(input logic s_one, input logic s_zero,
                                            input logic qual, input logic single);
    logic go;
    go = single | qual;
    if (!go)                 return WR_NONE;
    else if (s_one && s_zero) return WR_CLASH;
    else if (s_one)          return WR_ONE;
    else if (s_zero)         return WR_ZERO;
    else                     return WR_NONE;
  endfunction
endpackage

// File: rtl/cram_select.sv
module cram_select #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS
) (
  input  logic [ROWS-1:0]  row_sel,
  input  logic [COLS-1:0]  col_sel,
  output logic [CELLS-1:0] hit
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign hit[r*COLS + c] = row_sel[r] & col_sel[c];
    end
  end
endmodule

// File: rtl/cram_cells.sv
module cram_cells
  import cram_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] hit,
  input  wr_act_t          act,
  output logic [CELLS-1:0] cells
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                          cells[i] <= 1'b0;
      else if (hit[i] && act == WR_ONE)  cells[i] <= 1'b1;
      else if (hit[i] && act == WR_ZERO) cells[i] <= 1'b0;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R6: cells outside the crossing never move
  p_hold_unselected_r6: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (((cells ^ $past(cells)) & ~$past(hit)) == '0));

  // R9: conflicting strobes leave everything intact
  p_clash_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(act) == WR_CLASH) |-> $stable(cells));

  // R5: a set-one action leaves every chosen cell at 1
  p_set_one_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(act) == WR_ONE) |-> (($past(hit) & ~cells) == '0));

  // R5: a set-zero action leaves every chosen cell at 0
  p_set_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(act) == WR_ZERO) |-> (($past(hit) & cells) == '0));
endmodule

// File: rtl/cram_sense.sv
module cram_sense #(
  parameter int CELLS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] hit,
  input  logic [CELLS-1:0] cells,
  output logic             sense_one_n,
  output logic             sense_zero_n
);
  // Each chosen cell pulls one line low; the lines are wired-AND.
  assign sense_one_n  = ~|(hit & cells);
  assign sense_zero_n = ~|(hit & ~cells);

  // R3: idle array leaves both lines high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |-> (sense_one_n && sense_zero_n));

  // R4: a single chosen cell drives exactly one line low
  p_one_line_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot(hit) |-> (sense_one_n != sense_zero_n));
endmodule

// File: rtl/coincident_ram.sv
module coincident_ram
  import cram_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter bit SINGLE_GATE = 1'b0,
  localparam int CELLS = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  input  logic            wr_en,
  input  logic            set_one,
  input  logic            set_zero,
  output logic            sense_one_n,
  output logic            sense_zero_n
);
  logic [CELLS-1:0] hit;
  logic [CELLS-1:0] cells;
  wr_act_t          act;

  assign act = resolve_write(set_one, set_zero, wr_en, SINGLE_GATE);

  cram_select #(.ROWS(ROWS), .COLS(COLS)) u_sel (
    .row_sel (row_sel),
    .col_sel (col_sel),
    .hit     (hit)
  );

  cram_cells #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .act   (act),
    .cells (cells)
  );

  cram_sense #(.CELLS(CELLS)) u_sense (
    .clk          (clk),
    .rst          (rst),
    .hit          (hit),
    .cells        (cells),
    .sense_one_n  (sense_one_n),
    .sense_zero_n (sense_zero_n)
  );

  // R2: a half-selected matrix never raises a sense indication
  p_half_select_r2: assert property (@(posedge clk) disable iff (rst)
    (row_sel == '0 || col_sel == '0) |-> (sense_one_n && sense_zero_n));
endmodule

// File: tb/sim_coincident_ram.sv
module sim_coincident_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_sel = '0;
  logic [3:0] col_sel = '0;
  logic       wr_en = 1'b0;
  logic       set_one = 1'b0;
  logic       set_zero = 1'b0;
  logic       s1n_a, s0n_a, s1n_b, s0n_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_a = '0;  // model of two-gate build
  logic [15:0] m_b = '0;  // model of single-gate build

  always #2 clk = ~clk;  // 250 MHz

  coincident_ram #(.SINGLE_GATE(1'b0)) u0 (
    .clk(clk), .rst(rst), .row_sel(row_sel), .col_sel(col_sel),
    .wr_en(wr_en), .set_one(set_one), .set_zero(set_zero),
    .sense_one_n(s1n_a), .sense_zero_n(s0n_a));

  coincident_ram #(.SINGLE_GATE(1'b1)) u1 (
    .clk(clk), .rst(rst), .row_sel(row_sel), .col_sel(col_sel),
    .wr_en(wr_en), .set_one(set_one), .set_zero(set_zero),
    .sense_one_n(s1n_b), .sense_zero_n(s0n_b));

  // Line is low if any selected cell holds the value 'want'.
  function automatic logic line_n(input logic [15:0] m, input logic [3:0] r,
                                  input logic [3:0] c, input logic want);
    logic res;
    res = 1'b1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (r[i] && c[j] && m[i*4+j] == want) res = 1'b0;
    return res;
  endfunction

  task automatic compare(input string tag);
    logic e1a, e0a, e1b, e0b;
    e1a = line_n(m_a, row_sel, col_sel, 1'b1);
    e0a = line_n(m_a, row_sel, col_sel, 1'b0);
    e1b = line_n(m_b, row_sel, col_sel, 1'b1);
    e0b = line_n(m_b, row_sel, col_sel, 1'b0);
    checks += 2;
    if ({s1n_a, s0n_a} !== {e1a, e0a}) begin
      errors++;
      $display("FAIL %s two-gate: one_n/zero_n=%b%b expected %b%b (row=%b col=%b)",
               tag, s1n_a, s0n_a, e1a, e0a, row_sel, col_sel);
    end
    if ({s1n_b, s0n_b} !== {e1b, e0b}) begin
      errors++;
      $display("FAIL %s single-gate: one_n/zero_n=%b%b expected %b%b (row=%b col=%b)",
               tag, s1n_b, s0n_b, e1b, e0b, row_sel, col_sel);
    end
  endtask

  // Drive one cycle, compare before the edge, then advance the models.
  task automatic step(input logic [3:0] r, input logic [3:0] c, input logic g,
                      input logic s1, input logic s0, input string tag);
    @(negedge clk);
    row_sel = r; col_sel = c; wr_en = g; set_one = s1; set_zero = s0;
    #1;
    compare(tag);
    if (s1 && s0) $display("NOTE %s: illegal input, both write strobes high", tag);
    @(posedge clk);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (r[i] && c[j] && (s1 ^ s0)) begin
          if (g) m_a[i*4+j] = s1;
          m_b[i*4+j] = s1;
        end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        step(4'b1 << i, 4'b1 << j, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    // R1: synchronous reset clears every cell
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_b = '0;
    read_all("R1");

    // R3: nothing selected
    step(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, "R3");

    // R2: row-only and column-only selection with live write strobes
    step(4'b0100, 4'b0000, 1'b1, 1'b1, 1'b0, "R2");
    step(4'b0000, 4'b0010, 1'b1, 1'b1, 1'b0, "R2");
    step(4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0, "R2");
    read_all("R2");

    // R5: qualified writes of ones on a diagonal and a corner
    for (int k = 0; k < 4; k++)
      step(4'b1 << k, 4'b1 << k, 1'b1, 1'b1, 1'b0, "R5");
    step(4'b0001, 4'b1000, 1'b1, 1'b1, 1'b0, "R5");
    // R7/R6: released inputs, whole matrix read back
    step(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, "R7");
    read_all("R6");

    // R5/R8: strobes without qualifier, single-gate build writes
    step(4'b0010, 4'b0100, 1'b0, 1'b1, 1'b0, "R8");
    step(4'b1000, 4'b1000, 1'b0, 1'b0, 1'b1, "R8");
    step(4'b0010, 4'b0100, 1'b0, 1'b0, 1'b0, "R8");
    step(4'b1000, 4'b1000, 1'b0, 1'b0, 1'b0, "R5");

    // R5: qualified write of zero into a one
    step(4'b0001, 4'b0001, 1'b1, 1'b0, 1'b1, "R5");
    step(4'b0001, 4'b0001, 1'b0, 1'b0, 1'b0, "R4");

    // R9: both strobes on a cell holding 1 and on one holding 0
    step(4'b0100, 4'b0100, 1'b1, 1'b1, 1'b1, "R9");
    step(4'b0100, 4'b0100, 1'b0, 1'b0, 1'b0, "R9");
    step(4'b0100, 4'b0001, 1'b1, 1'b1, 1'b1, "R9");
    step(4'b0100, 4'b0001, 1'b0, 1'b0, 1'b0, "R9");
    read_all("R7");

    // R10: illegal multi-select, sense lines are wired-AND
    step(4'b0011, 4'b0011, 1'b0, 1'b0, 1'b0, "R10");
    step(4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, "R10");
    step(4'b0001, 4'b1001, 1'b0, 1'b0, 1'b0, "R10");
    step(4'b0110, 4'b0010, 1'b0, 1'b0, 1'b0, "R10");

    // R1: reset mid-run returns all cells to 0
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    m_a = '0; m_b = '0;
    @(negedge clk);
    rst = 1'b0;
    read_all("R1");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule